// File: doc/BRIEF.md
# Ethernet receive FIFO controller

This block sits between a MAC receive path and a DMA engine. The MAC pushes the words of each received frame, with start and end markers and per-byte enables. After the last data word it may send a two-word timestamp, low half first, and it always sends a status word. The controller stores all of this in one word-wide FIFO. Each entry carries a two-bit kind tag, so the DMA side can tell data, last data, timestamp and status words apart.

On the read side, the DMA is told when a frame may start. In store-and-forward mode this happens once a whole frame, including its status, is buffered. In cut-through mode it happens once enough bytes of the head frame are buffered or its last data word has arrived. After the first word is taken, the block keeps offering words whenever the FIFO holds any, until the frame's status word has been read.

When the FIFO runs short of space, the block never loses the end of a frame it has started. It keeps four entries in hand for a closing word, two timestamp words and the status. The frame is cut short, and its status records the overflow.

Top module: `erx_fifo_ctrl`

## Requirements
- R1: After reset the FIFO is empty and `dma_avail` and `dma_valid` are both 0.
- R2: Data words of a frame come out in arrival order with their byte enables. `dma_kind` is 0 for a data word, 1 for the last data word of a frame, 2 for a timestamp word and 3 for a status word.
- R3: With `ts_en` high, the two timestamp words that follow a frame's last data word are stored in arrival order (low half first), ahead of the status word. With `ts_en` low, timestamp words are discarded.
- R4: The status word is stored after the frame's data and timestamp. Reading it ends the transfer, and `dma_avail` is then re-evaluated for the next frame.
- R5: With `sf_mode` high, `dma_avail` rises only while at least one status word is in the FIFO.
- R6: With `sf_mode` low, `dma_avail` rises when the head frame's buffered byte count reaches the level chosen by `thr_code`, or when its last data word is stored. Codes 0, 1, 2 and 3 select 64, 32, 96 and 128 bytes; the byte count is the number of set enables.
- R7: A transfer starts when the DMA reads while `dma_avail` is high. Until the status word is read, `dma_valid` follows FIFO non-emptiness and `dma_avail` stays low.
- R8: A data word is stored only when at least five entries are free. Otherwise a closing entry (kind 1, enables 0, data 0) is stored and the rest of that frame's data is dropped. The frame's stored status then has bit 31 set.
- R9: A frame whose first word arrives with fewer than four free entries is discarded entirely, including its timestamp and status.
- R10: Data words arriving between frames without a start marker, and stray status words, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_en | input | 1 | Keep timestamp words |
| sf_mode | input | 1 | 1 = store-and-forward, 0 = cut-through |
| thr_code | input | 2 | Cut-through start level select |
| rx_valid | input | 1 | MAC word valid |
| rx_sof | input | 1 | First data word of a frame |
| rx_eof | input | 1 | Last data word of a frame |
| rx_ts | input | 1 | Word is a timestamp half |
| rx_stat | input | 1 | Word is the frame status |
| rx_be | input | 4 | Byte enables of a data word |
| rx_data | input | 32 | MAC word |
| dma_rd | input | 1 | DMA takes the offered word |
| dma_avail | output | 1 | A frame transfer may begin |
| dma_valid | output | 1 | A word is offered |
| dma_kind | output | 2 | Kind of the offered word |
| dma_be | output | 4 | Byte enables of the offered word |
| dma_data | output | 32 | Offered word |

## Verification
A word driven by the MAC is written at the next clock edge. From that edge on it can raise `dma_avail` and appear on `dma_data`, because both outputs are decoded from registered FIFO state. A read moves the head at the edge where `dma_rd` and `dma_valid` are both high, so the next word shows one cycle later. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a queue model. That model advances exactly once per rising edge, so every result is checked in the first cycle it is due, with no slack.

// File: rtl/erx_pkg.sv
package erx_pkg;
    parameter int WORD_W   = 32;
    localparam int BE_W     = WORD_W / 8;
    localparam int BE_CNT_W = $clog2(BE_W + 1);
    // entries kept in hand per open frame: closing word, two stamps, status
    localparam int RESERVE  = 4;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_EOF  = 2'd1,
        K_TS   = 2'd2,
        K_STAT = 2'd3
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e         kind;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } ent_t;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_FRAME,
        WS_OVF,
        WS_TAIL,
        WS_SKIP
    } wr_state_e;

    function automatic logic [7:0] thr_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd64;
            2'd1:    return 8'd32;
            2'd2:    return 8'd96;
            default: return 8'd128;
        endcase
    endfunction

    function automatic logic [BE_CNT_W-1:0] be_bytes(input logic [BE_W-1:0] be);
        logic [BE_CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BE_W; i++) n = n + BE_CNT_W'(be[i]);
        return n;
    endfunction
endpackage

// File: rtl/erx_wr_ctrl.sv
module erx_wr_ctrl
    import erx_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int OVF_BIT = 31,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_en,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_ts,
    input  logic              rx_stat,
    input  logic [BE_W-1:0]   rx_be,
    input  logic [WORD_W-1:0] rx_data,
    input  logic [CNT_W-1:0]  used,
    output logic              wr_en,
    output ent_t              wr_ent
);
    wr_state_e st, st_n;
    logic ovf_q, ovf_n, take;
    logic [CNT_W-1:0] free;
    logic is_data, is_ts, is_stat, room_data, room_frame;

    assign free       = CNT_W'(DEPTH) - used;
    assign is_data    = rx_valid && !rx_ts && !rx_stat;
    assign is_ts      = rx_valid && rx_ts;
    assign is_stat    = rx_valid && rx_stat;
    assign room_data  = free >= CNT_W'(RESERVE + 1);
    assign room_frame = free >= CNT_W'(RESERVE);

    always_comb begin
        st_n   = st;
        ovf_n  = ovf_q;
        take   = 1'b0;
        wr_en  = 1'b0;
        wr_ent = '0;
        case (st)
            WS_IDLE: if (is_data && rx_sof) begin
                if (room_frame) take = 1'b1;
                else            st_n = WS_SKIP;
            end
            WS_FRAME: if (is_data) take = 1'b1;
            WS_OVF:   if (is_data && rx_eof) st_n = WS_TAIL;
            WS_TAIL: begin
                if (is_ts && ts_en) begin
                    wr_en       = 1'b1;
                    wr_ent.kind = K_TS;
                    wr_ent.data = rx_data;
                end else if (is_stat) begin
                    wr_en       = 1'b1;
                    wr_ent.kind = K_STAT;
                    wr_ent.data = rx_data;
                    wr_ent.data[OVF_BIT] = rx_data[OVF_BIT] | ovf_q;
                    ovf_n = 1'b0;
                    st_n  = WS_IDLE;
                end
            end
            WS_SKIP:  if (is_stat) st_n = WS_IDLE;
            default:  st_n = WS_IDLE;
        endcase
        if (take) begin
            wr_en = 1'b1;
            if (room_data) begin
                wr_ent.kind = rx_eof ? K_EOF : K_DATA;
                wr_ent.be   = rx_be;
                wr_ent.data = rx_data;
                st_n = rx_eof ? WS_TAIL : WS_FRAME;
            end else begin
                wr_ent.kind = K_EOF;
                ovf_n = 1'b1;
                st_n  = rx_eof ? WS_TAIL : WS_OVF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= WS_IDLE;
            ovf_q <= 1'b0;
        end else begin
            st    <= st_n;
            ovf_q <= ovf_n;
        end
    end

    // R3
    ts_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ent.kind == K_TS) |-> ts_en);

    // R9
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == WS_SKIP) |-> !wr_en);
endmodule

// File: rtl/erx_fifo_mem.sv
module erx_fifo_mem
    import erx_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ent_t             wr_ent,
    input  logic             rd_en,
    output ent_t             head,
    output logic [CNT_W-1:0] used
);
    ent_t mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            used <= used + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    assign head = mem[rp];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |-> (used != CNT_W'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (used != '0));
endmodule

// File: rtl/erx_xfer_ctrl.sv
module erx_xfer_ctrl
    import erx_pkg::*;
#(
    parameter int DEPTH   = 64,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int BYTE_W = CNT_W + $clog2(BE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sf_mode,
    input  logic [1:0]       thr_code,
    input  logic             wr_en,
    input  ent_kind_e        wr_kind,
    input  logic [BE_W-1:0]  wr_be,
    input  ent_kind_e        head_kind,
    input  logic [BE_W-1:0]  head_be,
    input  logic [CNT_W-1:0] used,
    input  logic             rd_req,
    output logic             rd_en,
    output logic             dma_avail,
    output logic             dma_valid
);
    logic [BYTE_W-1:0] bytes_q;
    logic [CNT_W-1:0]  eof_q, stat_q;
    logic xfer_q, start_ok, wr_is_data, rd_is_data;
    logic [BE_CNT_W-1:0] add_b, sub_b;

    assign wr_is_data = wr_en && (wr_kind == K_DATA || wr_kind == K_EOF);
    assign rd_is_data = rd_en && (head_kind == K_DATA || head_kind == K_EOF);
    assign add_b = wr_is_data ? be_bytes(wr_be) : '0;
    assign sub_b = rd_is_data ? be_bytes(head_be) : '0;

    assign start_ok  = sf_mode ? (stat_q != '0)
                     : ((eof_q != '0) || (32'(bytes_q) >= 32'(thr_bytes(thr_code))));
    assign dma_avail = !xfer_q && start_ok && (used != '0);
    assign dma_valid = (xfer_q || dma_avail) && (used != '0);
    assign rd_en     = dma_valid && rd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            eof_q   <= '0;
            stat_q  <= '0;
            xfer_q  <= 1'b0;
        end else begin
            bytes_q <= bytes_q + BYTE_W'(add_b) - BYTE_W'(sub_b);
            eof_q   <= eof_q + CNT_W'(wr_en && wr_kind == K_EOF)
                             - CNT_W'(rd_en && head_kind == K_EOF);
            stat_q  <= stat_q + CNT_W'(wr_en && wr_kind == K_STAT)
                              - CNT_W'(rd_en && head_kind == K_STAT);
            if (rd_en) xfer_q <= (head_kind != K_STAT);
        end
    end

    // R7
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_q) |-> $past(dma_avail));

    // R4
    stat_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && head_kind == K_STAT) |=> !xfer_q);

    // R6
    byte_count_chk: assert property (@(posedge clk) disable iff (rst)
        rd_is_data |-> (bytes_q >= BYTE_W'(be_bytes(head_be))));
endmodule

// File: rtl/erx_fifo_ctrl.sv
module erx_fifo_ctrl
    import erx_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int OVF_BIT = 31,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_en,
    input  logic              sf_mode,
    input  logic [1:0]        thr_code,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_ts,
    input  logic              rx_stat,
    input  logic [3:0]        rx_be,
    input  logic [31:0]       rx_data,
    input  logic              dma_rd,
    output logic              dma_avail,
    output logic              dma_valid,
    output logic [1:0]        dma_kind,
    output logic [3:0]        dma_be,
    output logic [31:0]       dma_data
);
    logic wr_en, rd_en;
    ent_t wr_ent, head;
    logic [CNT_W-1:0] used;

    erx_wr_ctrl #(.DEPTH(DEPTH), .OVF_BIT(OVF_BIT)) u_wr (
        .clk(clk), .rst(rst), .ts_en(ts_en),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ts(rx_ts), .rx_stat(rx_stat), .rx_be(rx_be), .rx_data(rx_data),
        .used(used), .wr_en(wr_en), .wr_ent(wr_ent)
    );

    erx_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ent(wr_ent),
        .rd_en(rd_en), .head(head), .used(used)
    );

    erx_xfer_ctrl #(.DEPTH(DEPTH)) u_xfer (
        .clk(clk), .rst(rst), .sf_mode(sf_mode), .thr_code(thr_code),
        .wr_en(wr_en), .wr_kind(wr_ent.kind), .wr_be(wr_ent.be),
        .head_kind(head.kind), .head_be(head.be), .used(used),
        .rd_req(dma_rd), .rd_en(rd_en),
        .dma_avail(dma_avail), .dma_valid(dma_valid)
    );

    assign dma_kind = head.kind;
    assign dma_be   = head.be;
    assign dma_data = head.data;
endmodule

// File: tb/sim_erx_fifo_ctrl.sv
module sim_erx_fifo_ctrl;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ts_en = 1'b0, sf_mode = 1'b1;
    logic [1:0] thr_code = 2'd0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_ts = 1'b0, rx_stat = 1'b0;
    logic [3:0] rx_be = 4'h0;
    logic [31:0] rx_data = 32'h0;
    logic dma_rd = 1'b0;
    logic dma_avail, dma_valid;
    logic [1:0] dma_kind;
    logic [3:0] dma_be;
    logic [31:0] dma_data;

    always #4 clk = ~clk;

    erx_fifo_ctrl #(.DEPTH(DEPTH), .OVF_BIT(31)) u0 (
        .clk(clk), .rst(rst), .ts_en(ts_en), .sf_mode(sf_mode), .thr_code(thr_code),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_ts(rx_ts),
        .rx_stat(rx_stat), .rx_be(rx_be), .rx_data(rx_data), .dma_rd(dma_rd),
        .dma_avail(dma_avail), .dma_valid(dma_valid), .dma_kind(dma_kind),
        .dma_be(dma_be), .dma_data(dma_data)
    );

    typedef struct { int kind; int be; logic [31:0] data; } m_ent_t;
    m_ent_t mq[$];
    int  ms = 0;          // 0 idle, 1 in frame, 2 dropping, 3 tail, 4 discard
    bit  movf = 0, mxfer = 0;
    int  nchk = 0, nerr = 0, cyc = 0, rd_mode = 0;
    string tag = "R1";
    bit  done = 0;

    function automatic int popcnt(int be);
        int n = 0;
        for (int i = 0; i < 4; i++) n += (be >> i) & 1;
        return n;
    endfunction

    function automatic int thr_of(int c);
        case (c)
            0: return 64;
            1: return 32;
            2: return 96;
            default: return 128;
        endcase
    endfunction

    function automatic bit m_avail();
        int b = 0;
        bit e = 0, s = 0;
        if (mxfer || mq.size() == 0) return 0;
        foreach (mq[i]) begin
            if (mq[i].kind <= 1) b += popcnt(mq[i].be);
            if (mq[i].kind == 1) e = 1;
            if (mq[i].kind == 3) s = 1;
        end
        if (sf_mode) return s;
        return e || (b >= thr_of(int'(thr_code)));
    endfunction

    task automatic chk(bit ok, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(int k, int be, logic [31:0] d);
        m_ent_t e;
        e.kind = k; e.be = be; e.data = d;
        mq.push_back(e);
    endtask

    task automatic step();
        bit av, vl, isd;
        int fr, k;
        m_ent_t h;
        dma_rd = (rd_mode == 1) || (rd_mode == 2 && (cyc % 3) != 0);
        #1;
        av = m_avail();
        vl = (mxfer || av) && mq.size() > 0;
        chk(dma_avail === av, "avail", dma_avail, av);
        chk(dma_valid === vl, "valid", dma_valid, vl);
        if (vl) begin
            h = mq[0];
            chk(dma_kind === 2'(h.kind), "kind", dma_kind, h.kind);
            chk(dma_be === 4'(h.be), "be", dma_be, h.be);
            chk(dma_data === h.data, "data", dma_data, h.data);
        end
        fr = DEPTH - mq.size();
        if (dma_rd && vl) begin
            k = mq[0].kind;
            void'(mq.pop_front());
            mxfer = (k != 3);
        end
        isd = rx_valid && !rx_ts && !rx_stat;
        case (ms)
            0: if (isd && rx_sof) begin
                   if (fr < 4) ms = 4;
                   else if (fr >= 5) begin push(rx_eof ? 1 : 0, int'(rx_be), rx_data); ms = rx_eof ? 3 : 1; end
                   else begin push(1, 0, 32'h0); movf = 1; ms = rx_eof ? 3 : 2; end
               end
            1: if (isd) begin
                   if (fr >= 5) begin push(rx_eof ? 1 : 0, int'(rx_be), rx_data); ms = rx_eof ? 3 : 1; end
                   else begin push(1, 0, 32'h0); movf = 1; ms = rx_eof ? 3 : 2; end
               end
            2: if (isd && rx_eof) ms = 3;
            3: begin
                   if (rx_valid && rx_ts && ts_en) push(2, 0, rx_data);
                   else if (rx_valid && rx_stat) begin
                       push(3, 0, rx_data | (movf ? 32'h8000_0000 : 32'h0));
                       movf = 0; ms = 0;
                   end
               end
            default: if (rx_valid && rx_stat) ms = 0;
        endcase
        @(negedge clk);
        cyc++;
    endtask

    task automatic put(bit v, bit s, bit e, bit t, bit st, logic [3:0] be, logic [31:0] d);
        rx_valid = v; rx_sof = s; rx_eof = e; rx_ts = t; rx_stat = st; rx_be = be; rx_data = d;
        step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put(0, 0, 0, 0, 0, 4'h0, 32'h0);
    endtask

    task automatic send_frame(int nw, logic [3:0] lbe, bit ts, logic [31:0] base);
        for (int i = 0; i < nw; i++)
            put(1, i == 0, i == nw - 1, 0, 0, (i == nw - 1) ? lbe : 4'hF, base + 32'(i));
        if (ts) begin
            put(1, 0, 0, 1, 0, 4'h0, base ^ 32'h0000_5A5A);
            put(1, 0, 0, 1, 0, 4'h0, base ^ 32'h5A5A_0000);
        end
        put(1, 0, 0, 0, 1, 4'h0, 32'h0000_0C00 | base[15:0]);
        put(0, 0, 0, 0, 0, 4'h0, 32'h0);
    endtask

    task automatic drain();
        rd_mode = 1;
        for (int i = 0; i < 400 && (mq.size() != 0 || mxfer); i++) idle(1);
        idle(2);
        chk(mq.size() == 0 && !mxfer, "drained", mq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        idle(2);
        // R2 and R4: store-and-forward, plain frame, partial last word
        tag = "R2"; sf_mode = 1; ts_en = 0; rd_mode = 1;
        send_frame(5, 4'h3, 0, 32'h1000_0000);
        drain();
        tag = "R4";
        send_frame(2, 4'hF, 0, 32'h1100_0000);
        send_frame(1, 4'h1, 0, 32'h1200_0000);
        drain();
        // R3: timestamps kept, then discarded
        tag = "R3"; ts_en = 1;
        send_frame(4, 4'h7, 1, 32'h2000_0000);
        drain();
        ts_en = 0;
        send_frame(3, 4'hF, 1, 32'h2100_0000);
        drain();
        // R5: long frame, reader ready, store-and-forward
        tag = "R5"; sf_mode = 1; ts_en = 1; rd_mode = 1;
        send_frame(40, 4'hF, 1, 32'h3000_0000);
        drain();
        // R6: cut-through at each level, then a short frame
        tag = "R6"; sf_mode = 0; ts_en = 0;
        for (int c = 0; c < 4; c++) begin
            thr_code = 2'(c); rd_mode = 1;
            send_frame(40, 4'hF, 0, 32'h4000_0000 + 32'(c << 16));
            drain();
            send_frame(3, 4'h1, 0, 32'h4800_0000 + 32'(c << 16));
            drain();
        end
        // R7: cut-through with a stalling reader
        tag = "R7"; thr_code = 2'd1; ts_en = 1; rd_mode = 2;
        send_frame(30, 4'hF, 1, 32'h5000_0000);
        rd_mode = 2; idle(20);
        drain();
        // R8: frame longer than the FIFO, no reader
        tag = "R8"; sf_mode = 1; ts_en = 1; rd_mode = 0;
        send_frame(70, 4'hF, 1, 32'h6000_0000);
        idle(3);
        drain();
        // R9: fill until a new frame cannot start
        tag = "R9"; ts_en = 0; rd_mode = 0;
        send_frame(55, 4'hF, 0, 32'h7000_0000);
        send_frame(3, 4'hF, 0, 32'h7100_0000);
        send_frame(4, 4'hF, 0, 32'h7200_0000);
        send_frame(2, 4'hF, 0, 32'h7300_0000);
        idle(2);
        drain();
        // R10: stray words between frames
        tag = "R10"; rd_mode = 1;
        put(1, 0, 0, 0, 0, 4'hF, 32'h8000_0001);
        put(1, 0, 1, 0, 0, 4'hF, 32'h8000_0002);
        put(1, 0, 0, 0, 1, 4'h0, 32'h8000_0003);
        idle(3);
        chk(mq.size() == 0, "stray_ignored", mq.size(), 0);
        send_frame(2, 4'hF, 0, 32'h8100_0000);
        drain();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL %s watchdog act=%0d exp=%0d", tag, cyc, 0);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule